// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous memory that is accessed in bursts of four beats. When a burst starts, it captures an external address. It then generates the following addresses itself by stepping only the two least-significant bits. The upper bits stay in a register for the whole burst.

A burst can be started from either of two active-low strobes. The processor strobe only counts while the primary chip select is low. The cache-controller strobe counts regardless of chip select. After a load, the beat counter moves forward only in cycles where the active-low advance input is low. A static mode input picks the beat order: linear (base, base+1, base+2, base+3, modulo 4) or interleaved (base XOR 0, 1, 2, 3).

The outputs are the full current address and a flag that is high while a burst is in progress. Every input is sampled on the rising clock edge. The address output is a direct function of the registered state, so it shows the new value right after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising edge, the design clears itself. After that edge `addr_out` is 0 and `burst_active` is 0.
- R2: `cc_strobe_n` low at a rising edge loads `addr_in`, whatever the level of `cs_n`. After that edge `addr_out` equals `addr_in` and `burst_active` is 1.
- R3: `ps_strobe_n` low at a rising edge loads `addr_in` when `cs_n` is low. When `cs_n` is high it is ignored: `addr_out` and `burst_active` keep their values.
- R4: If both strobes are low in the same cycle, exactly one load of `addr_in` takes place. The processor path is used when `cs_n` is low; otherwise the cache-controller path is used.
- R5: While `burst_active` is 1 and no strobe loads, `adv_n` low advances the beat count by one at the edge. `adv_n` high holds `addr_out` unchanged.
- R6: With `interleave` = 0, beat k (k = 0..3) drives `addr_out[1:0]` = (base + k) mod 4, where base is the loaded `addr_in[1:0]`.
- R7: With `interleave` = 1, beat k drives `addr_out[1:0]` = base XOR k.
- R8: `addr_out[ADDR_W-1:2]` changes only on a load. Beat stepping never carries into the upper bits.
- R9: An advance taken on beat 3 wraps the address back to the base and clears `burst_active`. While `burst_active` is 0, `adv_n` has no effect.
- R10: A valid strobe during a burst restarts the burst at the new address. The load takes precedence over a simultaneous advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address, loaded on a valid strobe |
| ps_strobe_n | input | 1 | Processor address strobe, active low, gated by `cs_n` |
| cc_strobe_n | input | 1 | Cache-controller address strobe, active low, not gated |
| cs_n | input | 1 | Primary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |
| burst_active | output | 1 | High while a burst has beats left |

## Verification
The bench runs every beat of all four start offsets in both orders and compares each one with a model of the sum and XOR orders. A design that mixed up the two orders, or let the low bits carry, would fail on these beats. Other tests drive the processor strobe with the chip select high, both with and without the cache strobe. A design that ignores the gating would load when it should not, and one that only honours the processor strobe would miss the cache-path load. Further tests hold the advance input high in the middle of a burst, advance past the fourth beat, keep advancing while idle, and restart in the middle of a burst. These expose a counter that drifts, fails to wrap to the base, leaves the active flag set, or lets an advance beat a load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef logic [1:0] beat_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PROC  = 2'd1,
        SRC_CACHE = 2'd2
    } load_src_e;

    // Low address bits for beat k from base, in linear or interleaved order.
    function automatic beat_t burst_low(input beat_t base, input beat_t k, input logic ilv);
        beat_t r;
        if (ilv) r = base ^ k;
        else     r = base + k;
        return r;
    endfunction

endpackage

// File: rtl/bseq_strobe_arb.sv
module bseq_strobe_arb
    import bseq_pkg::*;
(
    input  logic      ps_strobe_n,
    input  logic      cc_strobe_n,
    input  logic      cs_n,
    output load_src_e src
);
    logic ps_ok;

    always_comb begin
        ps_ok = !ps_strobe_n && !cs_n;
        if (ps_ok)             src = SRC_PROC;
        else if (!cc_strobe_n) src = SRC_CACHE;
        else                   src = SRC_NONE;
    end

    // R4: a processor strobe that chip select allows always wins
    always_comb begin
        if (!ps_strobe_n && !cs_n)
            a_r4_proc_priority: assert (src == SRC_PROC);
    end
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-3:0] upper,
    output beat_t             base
);
    always_ff @(posedge clk) begin
        if (rst) begin
            upper <= '0;
            base  <= '0;
        end else if (load) begin
            upper <= addr_in[ADDR_W-1:2];
            base  <= addr_in[1:0];
        end
    end

    // R8: upper bits move only on a load
    a_r8_upper_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> (upper == $past(upper)));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  adv,
    output beat_t beat,
    output logic  active
);
    localparam beat_t LAST_BEAT = 2'd3;

    logic step;
    assign step = adv && active && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat   <= '0;
            active <= 1'b0;
        end else if (load) begin
            beat   <= '0;
            active <= 1'b1;
        end else if (step) begin
            beat <= beat + 2'd1;
            if (beat == LAST_BEAT) active <= 1'b0;
        end
    end

    // R5: an advance during a burst moves exactly one beat
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        (active && adv && !load) |=> (beat == $past(beat) + 2'd1));
    // R9: advancing from the last beat ends the burst at beat 0
    a_r9_wrap_end: assert property (@(posedge clk) disable iff (rst)
        (active && adv && !load && beat == LAST_BEAT) |=> (!active && beat == 2'd0));
    // R9: idle advances do nothing
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> ($stable(beat) && !active));
    // R10: a load restarts at beat 0
    a_r10_load_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> (beat == 2'd0 && active));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ps_strobe_n,
    input  logic              cc_strobe_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);
    load_src_e         src;
    logic              load;
    logic [ADDR_W-3:0] upper;
    beat_t             base;
    beat_t             beat;

    bseq_strobe_arb u_arb (
        .ps_strobe_n (ps_strobe_n),
        .cc_strobe_n (cc_strobe_n),
        .cs_n        (cs_n),
        .src         (src)
    );

    assign load = (src != SRC_NONE);

    bseq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_in (addr_in),
        .upper   (upper),
        .base    (base)
    );

    bseq_beat_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .adv    (!adv_n),
        .beat   (beat),
        .active (burst_active)
    );

    assign addr_out = {upper, burst_low(base, beat, interleave)};

    // R2: the cache strobe loads regardless of chip select
    a_r2_cache_load: assert property (@(posedge clk) disable iff (rst)
        !cc_strobe_n |=> (addr_out == $past(addr_in) && burst_active));
    // R3: the gated processor strobe alone changes nothing
    a_r3_gated_ignored: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !ps_strobe_n && cc_strobe_n && adv_n) |=>
        (addr_out == $past(addr_out) && burst_active == $past(burst_active)));
    // R5: no advance and no strobe holds the address
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (adv_n && ps_strobe_n && cc_strobe_n) |=> $stable(addr_out));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int ADDR_W = 17;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr_in;
    logic              ps_strobe_n, cc_strobe_n, cs_n, adv_n, interleave;
    logic [ADDR_W-1:0] addr_out;
    logic              burst_active;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .addr_in(addr_in), .ps_strobe_n(ps_strobe_n),
        .cc_strobe_n(cc_strobe_n), .cs_n(cs_n), .adv_n(adv_n),
        .interleave(interleave), .addr_out(addr_out), .burst_active(burst_active)
    );

    function automatic logic [1:0] ref_low(input logic [1:0] b, input int k, input logic ilv);
        logic [1:0] kk = k[1:0];
        return ilv ? (b ^ kk) : (b + kk);
    endfunction

    task automatic check(input string req, input logic [ADDR_W-1:0] exp_a, input logic exp_act);
        n_cmp++;
        if (addr_out !== exp_a || burst_active !== exp_act) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h active=%0b expected addr_out=%h active=%0b",
                     req, addr_out, burst_active, exp_a, exp_act);
        end
    endtask

    // drive at falling edge, apply one rising edge, sample 1ns later
    task automatic cyc(input logic [ADDR_W-1:0] a, input logic ps, input logic cc,
                       input logic cs, input logic adv);
        @(negedge clk);
        addr_in = a; ps_strobe_n = ps; cc_strobe_n = cc; cs_n = cs; adv_n = adv;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc('0, 1, 1, 1, 1);
        cyc('0, 1, 1, 1, 1);
        check("R1 reset", '0, 1'b0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_full_orders();
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 4; b++) begin
                logic [ADDR_W-1:0] a = {15'h4A5B, 2'(b)};
                interleave = m[0];
                cyc(a, 1, 0, 1, 1);
                check("R2 cache load", a, 1'b1);
                for (int k = 1; k < 4; k++) begin
                    cyc('1, 1, 1, 1, 0);
                    check(m == 0 ? "R6 linear beat" : "R7 interleaved beat",
                          {a[ADDR_W-1:2], ref_low(2'(b), k, m[0])}, 1'b1);
                end
                cyc('1, 1, 1, 1, 0);
                check("R9 wrap to base, R8 upper kept", a, 1'b0);
            end
        end
        interleave = 1'b0;
    endtask

    task automatic t_gating();
        logic [ADDR_W-1:0] a = 17'h1_2345;
        cyc(a, 1, 0, 1, 1);
        check("R2 load with cs_n high", a, 1'b1);
        cyc(17'h0_0F0E, 0, 1, 1, 1);
        check("R3 gated processor strobe ignored", a, 1'b1);
        cyc(17'h0_0F0E, 0, 1, 0, 1);
        check("R3 processor strobe with cs_n low", 17'h0_0F0E, 1'b1);
        cyc(17'h1_7777, 0, 0, 1, 1);
        check("R4 both strobes, cs_n high, cache path", 17'h1_7777, 1'b1);
        cyc(17'h0_3332, 0, 0, 0, 1);
        check("R4 both strobes, cs_n low", 17'h0_3332, 1'b1);
    endtask

    task automatic t_hold_and_idle();
        logic [ADDR_W-1:0] a = 17'h0_ABC1;
        interleave = 1'b1;
        cyc(a, 0, 1, 0, 1);
        cyc('0, 1, 1, 1, 0);
        check("R7 first beat", {a[ADDR_W-1:2], 2'b00}, 1'b1);
        cyc('0, 1, 1, 1, 1);
        cyc('0, 1, 1, 1, 1);
        check("R5 adv_n high holds", {a[ADDR_W-1:2], 2'b00}, 1'b1);
        cyc('0, 1, 1, 1, 0);
        cyc('0, 1, 1, 1, 0);
        cyc('0, 1, 1, 1, 0);
        check("R9 burst end", a, 1'b0);
        cyc('0, 1, 1, 1, 0);
        cyc('0, 1, 1, 1, 0);
        check("R9 idle advance ignored", a, 1'b0);
        interleave = 1'b0;
    endtask

    task automatic t_restart();
        cyc(17'h1_0002, 1, 0, 1, 1);
        cyc('0, 1, 1, 1, 0);
        check("R6 linear 2->3", 17'h1_0003, 1'b1);
        cyc(17'h0_5551, 1, 0, 1, 0);
        check("R10 load beats advance", 17'h0_5551, 1'b1);
        cyc('0, 1, 1, 1, 0);
        check("R10 restarted burst steps", 17'h0_5552, 1'b1);
        cyc('0, 1, 1, 1, 0);
        check("R8 no carry into upper", 17'h0_5553, 1'b1);
        cyc('0, 1, 1, 1, 0);
        check("R8 wrap stays in block", 17'h0_5550, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; addr_in = '0; ps_strobe_n = 1'b1; cc_strobe_n = 1'b1;
        cs_n = 1'b1; adv_n = 1'b1; interleave = 1'b0;
        t_reset();
        t_full_orders();
        t_gating();
        t_hold_and_idle();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule